// File: doc/BRIEF.md
# MIDI Host Port with UART-Only Command Set

This block is the host-facing side of a MIDI interface that follows the classic two-register layout. One byte offset holds the data register. The next offset holds the command register when written and the status register when read. The port supports only the pass-through (UART) mode. It recognises two command codes, a reset and a switch into UART mode. It answers each accepted command by placing an acknowledge byte in front of any received MIDI traffic.

In UART mode, host writes to the data register are handed to an external transmit FIFO, and host reads pop bytes from an external receive FIFO. Two status bits, both active low, tell the host when a byte is waiting and when the transmit side can take one. Two event outputs go to the interrupt controller: one when the transmit FIFO drains, one when the readable data runs out. The serial bit engine sits outside this block.

Top module: `midi_uart_port`

## Requirements
- R1: After reset the port is out of UART mode, no acknowledge is pending, and a status read returns bit 7 = 1, bit 6 = tx_full, bits 5:0 = 0.
- R2: A command write of 0xFF leaves UART mode and pulses tx_flush and rx_flush in the cycle of the write. Afterwards exactly one acknowledge is pending, and any older acknowledges are discarded.
- R3: A command write of 0x3F outside UART mode enters UART mode and queues one acknowledge. Inside UART mode it changes nothing and queues no acknowledge.
- R4: Any command byte other than 0xFF and 0x3F changes neither the mode nor the acknowledge queue.
- R5: A data-register read returns the acknowledge byte 0xFE while one is pending, without popping the receive FIFO. Only when no acknowledge is pending does a read in UART mode with rx_valid = 1 return rx_data and raise rx_pop for that one cycle.
- R6: Status bit 7 is 0 exactly when an acknowledge is pending, or when the port is in UART mode and rx_valid = 1. Outside UART mode, rx_valid has no effect.
- R7: Status bit 6 equals tx_full (0 means a byte can be accepted).
- R8: A data-register write drives tx_valid = 1 with tx_data = the written byte in the same cycle, only when in UART mode and tx_full = 0. Otherwise the byte is dropped.
- R9: A data-register read while status bit 7 = 1 returns the last byte delivered by a data read, and does not pop the receive FIFO.
- R10: irq_tx_empty pulses for one cycle when tx_empty rises while the port is in UART mode.
- R11: irq_rx_empty pulses for one cycle, in the cycle after readable data goes from available to unavailable.
- R12: Read data appears on rd_data in the clock cycle after the one in which rd_en is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | ADDR_W | Host byte offset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Host read byte, registered |
| tx_valid | output | 1 | Push byte into transmit FIFO |
| tx_data | output | 8 | Byte pushed into transmit FIFO |
| tx_full | input | 1 | Transmit FIFO cannot accept a byte |
| tx_empty | input | 1 | Transmit FIFO holds no bytes |
| tx_flush | output | 1 | Clear the transmit FIFO |
| rx_valid | input | 1 | Receive FIFO has a byte at its head |
| rx_data | input | 8 | Head byte of receive FIFO |
| rx_pop | output | 1 | Remove head byte of receive FIFO |
| rx_flush | output | 1 | Clear the receive FIFO |
| irq_tx_empty | output | 1 | Transmit-empty event |
| irq_rx_empty | output | 1 | Receive-empty event |

## Verification
The bench builds the port with its defaults: an 8-bit offset bus with the data register at 0x18 and commands at 0x19, an acknowledge queue of depth 2, and pulse-style events. These values reach the ordering corner where an acknowledge and a MIDI byte are both waiting. They also reach the event edges, which only the pulse variant produces. The bench models both FIFOs with plain flags, so drops, flushes and pops are all visible directly at the pins.

// File: rtl/midi_port_pkg.sv
package midi_port_pkg;

   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_RESET = 2'd1,
      CMD_UART  = 2'd2
   } cmd_kind_e;

   localparam int unsigned IN_BUSY_BIT  = 7;
   localparam int unsigned OUT_BUSY_BIT = 6;

endpackage

// File: rtl/mpu_cmd_decode.sv
module mpu_cmd_decode
   import midi_port_pkg::*;
#(
   parameter logic [7:0] RESET_CODE = 8'hFF,
   parameter logic [7:0] UART_CODE  = 8'h3F
) (
   input  logic      cmd_wr,
   input  logic [7:0] cmd_byte,
   input  logic      in_uart,
   output cmd_kind_e kind
);

   always_comb begin
      kind = CMD_NONE;
      if (cmd_wr) begin
         if (cmd_byte == RESET_CODE)
            kind = CMD_RESET;
         else if (cmd_byte == UART_CODE && !in_uart)
            kind = CMD_UART;
      end
   end

endmodule

// File: rtl/mpu_ack_queue.sv
module mpu_ack_queue #(
   parameter int unsigned DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_one,
   input  logic push,
   input  logic pop,
   output logic pending
);

   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_one)
         cnt_q <= CNT_ONE;
      else if (push && !pop && cnt_q != CNT_MAX)
         cnt_q <= cnt_q + CNT_ONE;
      else if (pop && !push && cnt_q != '0)
         cnt_q <= cnt_q - CNT_ONE;
   end

   assign pending = (cnt_q != '0);

   // R5
   ack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX);

   // R2
   ack_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_one |=> cnt_q == CNT_ONE);

endmodule

// File: rtl/mpu_irq_gen.sv
module mpu_irq_gen #(
   parameter bit PULSE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_uart,
   input  logic tx_empty,
   input  logic byte_avail,
   output logic irq_tx,
   output logic irq_rx
);

   logic tx_empty_q;
   logic avail_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_empty_q <= 1'b1;
         avail_q    <= 1'b0;
      end else begin
         tx_empty_q <= tx_empty;
         avail_q    <= byte_avail;
      end
   end

   generate
      if (PULSE) begin : g_pulse
         assign irq_tx = in_uart & tx_empty & ~tx_empty_q;
         assign irq_rx = avail_q & ~byte_avail;

         // R10
         irq_tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_tx |=> !irq_tx);

         // R11
         irq_rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_rx |=> !irq_rx);
      end else begin : g_level
         assign irq_tx = in_uart & tx_empty;
         assign irq_rx = in_uart & ~byte_avail;
      end
   endgenerate

endmodule

// File: rtl/midi_uart_port.sv
module midi_uart_port
   import midi_port_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter logic [7:0]  DATA_OFS   = 8'h18,
   parameter int unsigned ACK_DEPTH  = 2,
   parameter logic [7:0]  ACK_BYTE   = 8'hFE,
   parameter logic [7:0]  RESET_CODE = 8'hFF,
   parameter logic [7:0]  UART_CODE  = 8'h3F,
   parameter bit          IRQ_PULSE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              wr_en,
   input  logic [7:0]        wr_data,
   input  logic              rd_en,
   output logic [7:0]        rd_data,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   input  logic              tx_full,
   input  logic              tx_empty,
   output logic              tx_flush,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   output logic              rx_pop,
   output logic              rx_flush,
   output logic              irq_tx_empty,
   output logic              irq_rx_empty
);

   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(DATA_OFS + 8'd1);

   generate
      if (ACK_DEPTH < 1) begin : g_bad_depth
         $error("ACK_DEPTH must be at least 1");
      end
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie in 1..32");
      end
      if (RESET_CODE == UART_CODE) begin : g_bad_codes
         $error("command codes must differ");
      end
   endgenerate

   logic      data_sel, stat_sel;
   logic      cmd_wr, data_wr, data_rd, stat_rd;
   cmd_kind_e kind;
   logic      is_rst, is_uart;
   logic      uart_q;
   logic      ack_pending;
   logic      rx_avail, byte_avail;
   logic      take_ack, take_rx;
   logic [7:0] status;
   logic [7:0] last_q;
   logic [7:0] rd_q;

   assign data_sel = (host_addr == DATA_A);
   assign stat_sel = (host_addr == STAT_A);
   assign cmd_wr   = wr_en & stat_sel;
   assign data_wr  = wr_en & data_sel;
   assign data_rd  = rd_en & data_sel;
   assign stat_rd  = rd_en & stat_sel;

   mpu_cmd_decode #(
      .RESET_CODE (RESET_CODE),
      .UART_CODE  (UART_CODE)
   ) u_dec (
      .cmd_wr   (cmd_wr),
      .cmd_byte (wr_data),
      .in_uart  (uart_q),
      .kind     (kind)
   );

   assign is_rst  = (kind == CMD_RESET);
   assign is_uart = (kind == CMD_UART);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         uart_q <= 1'b0;
      else if (is_rst)
         uart_q <= 1'b0;
      else if (is_uart)
         uart_q <= 1'b1;
   end

   assign take_ack = data_rd & ack_pending;

   mpu_ack_queue #(
      .DEPTH (ACK_DEPTH)
   ) u_ackq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_one (is_rst),
      .push     (is_uart),
      .pop      (take_ack),
      .pending  (ack_pending)
   );

   assign rx_avail   = uart_q & rx_valid;
   assign byte_avail = ack_pending | rx_avail;
   assign take_rx    = data_rd & ~ack_pending & rx_avail;

   assign rx_pop   = take_rx;
   assign tx_valid = data_wr & uart_q & ~tx_full;
   assign tx_data  = wr_data;
   assign tx_flush = is_rst;
   assign rx_flush = is_rst;

   always_comb begin
      status = '0;
      status[IN_BUSY_BIT]  = ~byte_avail;
      status[OUT_BUSY_BIT] = tx_full;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= '0;
         rd_q   <= '0;
      end else begin
         if (take_ack)
            last_q <= ACK_BYTE;
         else if (take_rx)
            last_q <= rx_data;

         if (stat_rd)
            rd_q <= status;
         else if (data_rd) begin
            if (take_ack)
               rd_q <= ACK_BYTE;
            else if (take_rx)
               rd_q <= rx_data;
            else
               rd_q <= last_q;
         end
      end
   end

   assign rd_data = rd_q;

   mpu_irq_gen #(
      .PULSE (IRQ_PULSE)
   ) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_uart    (uart_q),
      .tx_empty   (tx_empty),
      .byte_avail (byte_avail),
      .irq_tx     (irq_tx_empty),
      .irq_rx     (irq_rx_empty)
   );

   // R2
   rst_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wr_data == RESET_CODE) |=> (!uart_q && ack_pending));

   // R3
   uart_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uart_q && cmd_wr && wr_data == UART_CODE) |=> uart_q);

   // R5
   ack_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && ack_pending) |=> rd_data == ACK_BYTE);

   // R9
   idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !byte_avail) |=> (rd_data == $past(last_q) && $stable(last_q)));

   // R8
   tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !tx_full);

   // R12
   stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> rd_data == $past(status));

endmodule

// File: tb/midi_uart_port_tb.sv
module midi_uart_port_tb;

   localparam logic [7:0] A_DATA = 8'h18;
   localparam logic [7:0] A_STAT = 8'h19;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] host_addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       tx_valid;
   logic [7:0] tx_data;
   logic       tx_full = 1'b0;
   logic       tx_empty = 1'b1;
   logic       tx_flush;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_pop;
   logic       rx_flush;
   logic       irq_tx_empty;
   logic       irq_rx_empty;

   int checks = 0;
   int errors = 0;
   logic seen_pop;
   logic [7:0] got;

   always #10 clk = ~clk;

   midi_uart_port u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_addr    (host_addr),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .rd_en        (rd_en),
      .rd_data      (rd_data),
      .tx_valid     (tx_valid),
      .tx_data      (tx_data),
      .tx_full      (tx_full),
      .tx_empty     (tx_empty),
      .tx_flush     (tx_flush),
      .rx_valid     (rx_valid),
      .rx_data      (rx_data),
      .rx_pop       (rx_pop),
      .rx_flush     (rx_flush),
      .irq_tx_empty (irq_tx_empty),
      .irq_rx_empty (irq_rx_empty)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [7:0] d, output logic pop);
      @(negedge clk);
      host_addr = a; rd_en = 1'b1;
      #1 pop = rx_pop;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic t_reset_state();
      bus_read(A_STAT, got, seen_pop);
      chk("R1 status after reset", got, 8'h80);
      chk("R1 tx_valid idle", {7'd0, tx_valid}, 8'h00);
      chk("R1 irqs idle", {6'd0, irq_tx_empty, irq_rx_empty}, 8'h00);
   endtask

   task automatic t_unknown_cmd_and_drop();
      bus_write(A_STAT, 8'h12);
      bus_read(A_STAT, got, seen_pop);
      chk("R4 unknown command ignored", got, 8'h80);
      @(negedge clk);
      host_addr = A_DATA; wr_data = 8'h55; wr_en = 1'b1;
      #1 chk("R8 write outside UART dropped", {7'd0, tx_valid}, 8'h00);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_enter_uart();
      bus_write(A_STAT, 8'h3F);
      bus_read(A_STAT, got, seen_pop);
      chk("R3 enter UART queues ack", got, 8'h00);
      bus_read(A_DATA, got, seen_pop);
      chk("R5 ack byte", got, 8'hFE);
      chk("R11 rx-empty event after ack read", {7'd0, irq_rx_empty}, 8'h01);
      @(negedge clk);
      chk("R11 event is one cycle", {7'd0, irq_rx_empty}, 8'h00);
      bus_write(A_STAT, 8'h3F);
      bus_read(A_STAT, got, seen_pop);
      chk("R3 enter UART inside UART no ack", got, 8'h80);
   endtask

   task automatic t_transmit();
      @(negedge clk);
      host_addr = A_DATA; wr_data = 8'hA5; wr_en = 1'b1;
      #1 chk("R8 forward valid", {7'd0, tx_valid}, 8'h01);
      chk("R8 forward data", tx_data, 8'hA5);
      @(negedge clk);
      wr_en = 1'b0; tx_full = 1'b1; tx_empty = 1'b0;
      bus_read(A_STAT, got, seen_pop);
      chk("R7 out-busy bit", got, 8'hC0);
      @(negedge clk);
      host_addr = A_DATA; wr_data = 8'h5A; wr_en = 1'b1;
      #1 chk("R8 write while full dropped", {7'd0, tx_valid}, 8'h00);
      @(negedge clk);
      wr_en = 1'b0; tx_full = 1'b0;
      @(negedge clk);
      tx_empty = 1'b1;
      #1 chk("R10 tx-empty event", {7'd0, irq_tx_empty}, 8'h01);
      @(negedge clk);
      chk("R10 event is one cycle", {7'd0, irq_tx_empty}, 8'h00);
   endtask

   task automatic t_receive();
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'h3C;
      bus_read(A_STAT, got, seen_pop);
      chk("R6 rx byte makes bit7 low", got, 8'h00);
      @(negedge clk);
      host_addr = A_DATA; rd_en = 1'b1;
      #1 seen_pop = rx_pop;
      @(negedge clk);
      rd_en = 1'b0; rx_valid = 1'b0;
      chk("R12 rx byte next cycle", rd_data, 8'h3C);
      chk("R5 rx pop", {7'd0, seen_pop}, 8'h01);
      #1 chk("R11 event after rx drained", {7'd0, irq_rx_empty}, 8'h01);
      bus_read(A_DATA, got, seen_pop);
      chk("R9 idle read repeats last", got, 8'h3C);
      chk("R9 idle read no pop", {7'd0, seen_pop}, 8'h00);
   endtask

   task automatic t_reset_cmd();
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'h77;
      host_addr = A_STAT; wr_data = 8'hFF; wr_en = 1'b1;
      #1 chk("R2 flush pulses", {6'd0, tx_flush, rx_flush}, 8'h03);
      @(negedge clk);
      wr_en = 1'b0;
      bus_read(A_STAT, got, seen_pop);
      chk("R2 ack pending after reset cmd", got, 8'h00);
      bus_read(A_DATA, got, seen_pop);
      chk("R2 reset ack byte", got, 8'hFE);
      bus_read(A_STAT, got, seen_pop);
      chk("R6 rx ignored outside UART", got, 8'h80);
      bus_read(A_DATA, got, seen_pop);
      chk("R9 no pop outside UART", {7'd0, seen_pop}, 8'h00);
      chk("R9 last byte kept", got, 8'hFE);
   endtask

   task automatic t_ordering();
      rx_data = 8'h99;
      bus_write(A_STAT, 8'h3F);
      bus_read(A_DATA, got, seen_pop);
      chk("R5 ack before rx data", got, 8'hFE);
      chk("R5 no pop while ack", {7'd0, seen_pop}, 8'h00);
      bus_read(A_DATA, got, seen_pop);
      chk("R5 rx data after ack", got, 8'h99);
      chk("R5 pop with rx data", {7'd0, seen_pop}, 8'h01);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_unknown_cmd_and_drop();
      t_enter_uart();
      t_transmit();
      t_receive();
      t_reset_cmd();
      t_ordering();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule